// File: doc/BRIEF.md
# Deferred-Fault Register and Predicate Unit

This unit holds the integer register file of an execution pipeline, with a one-bit invalid tag (NaT) stored beside every 64-bit register, plus a bank of one-bit predicate registers. A speculative load that meets a memory fault does not trap. It tags its destination register and writes a fixed marker value into it. The tag then follows the data through arithmetic. A later check operation decides whether recovery is needed, and if so it reports the recovery target address.

Compares write a pair of predicates: the result to one and its complement to the other. Every operation names a qualifying predicate, and an operation whose qualifying predicate reads 0 leaves all state as it was. The unit accepts one operation per cycle. The load response (data and a fault flag) arrives on the same cycle as the load operation. Register and predicate writes take effect at the next rising clock edge, and the fault and recovery outputs are registered.

Operation codes on `op_i`: 0 no-op, 1 add, 2 subtract, 3 compare-equal, 4 compare-less-than (unsigned), 5 load, 6 speculative load, 7 check.

Top module: `nat_spec_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every register reads 0 with its tag clear. `pred_o` reads 1 (only predicate 0 set), and `fault_o` and `recover_o` are low.
- R2: Add (op 1) writes src_a+src_b, and subtract (op 2) writes src_a-src_b, modulo 2^64. The destination's tag is the OR of the two source tags. The result is readable on the cycle after the operation.
- R3: A load (op 5) with `ld_fault_i` low writes `ld_data_i` to the destination and clears its tag.
- R4: A load (op 5) with `ld_fault_i` high leaves the destination unchanged and raises `fault_o` for exactly the following cycle.
- R5: A speculative load (op 6) with `ld_fault_i` high writes all ones to the destination and sets its tag, without raising `fault_o`. With `ld_fault_i` low it behaves like R3.
- R6: Compare-equal (op 3) and unsigned compare-less-than (op 4) write the result to predicate `pt_i` and its complement to predicate `pf_i`. If either source is tagged, both predicates are written 0.
- R7: A check (op 7) whose src_a register is tagged raises `recover_o` on the following cycle, with `recover_addr_o` equal to the `recov_addr_i` given with the check. A check on an untagged register leaves `recover_o` low.
- R8: An operation whose qualifying predicate `pred_o[qp_i]` is 0 changes no register, tag or predicate, and raises neither `fault_o` nor `recover_o`.
- R9: Register 0 always reads 0 with its tag clear, and writes to it are discarded.
- R10: Predicate 0 always reads 1 and writes to it are discarded, so `qp_i`=0 makes an operation unconditional. Only compares change `pred_o`.
- R11: A result without a tag clears the destination's tag, even when the destination was tagged before.
- R12: With `op_valid_i` low, or with op 0, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| qp_i | input | 6 | Qualifying predicate index |
| dst_i | input | 5 | Destination register index |
| src_a_i | input | 5 | First source register index |
| src_b_i | input | 5 | Second source register index |
| pt_i | input | 6 | Predicate receiving the compare result |
| pf_i | input | 6 | Predicate receiving the complement |
| recov_addr_i | input | 64 | Recovery target for a check |
| ld_data_i | input | 64 | Load response data |
| ld_fault_i | input | 1 | Load response fault flag |
| dbg_idx_i | input | 5 | Observation read index |
| dbg_data_o | output | 64 | Register value at `dbg_idx_i` |
| dbg_nat_o | output | 1 | Tag of register at `dbg_idx_i` |
| pred_o | output | 64 | All predicate values |
| recover_o | output | 1 | Recovery request, one cycle per check hit |
| recover_addr_o | output | 64 | Recovery target address |
| fault_o | output | 1 | Immediate fault from a non-speculative load |

## Verification
The tag logic is tried with clean-on-clean, tagged-on-clean and clean-over-tagged operand mixes. These cases separate an OR of the tags from a copy of a single source, and show whether a clean result really clears an old tag. Loads run in all four combinations of speculative or not and faulting or not, which separates deferral from the immediate fault. Compares run with true and false outcomes and with a tagged source, so a swapped pair or a missing clear shows up. Then every kind of operation runs under a false qualifying predicate and with targets 0, to show that nothing leaks through.

// File: rtl/nat_spec_pkg.sv
package nat_spec_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CEQ = 3'd3,
    OP_CLT = 3'd4,
    OP_LD  = 3'd5,
    OP_LDS = 3'd6,
    OP_CHK = 3'd7
  } op_e;
endpackage

// File: rtl/nat_spec_gpr.sv
module nat_spec_gpr #(
  parameter int DATA_W  = 64,
  parameter int NUM_GPR = 32,
  localparam int IDX_W  = $clog2(NUM_GPR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wnat_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic              ra_nat_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_nat_o,
  input  logic [IDX_W-1:0]  rc_idx_i,
  output logic [DATA_W-1:0] rc_data_o,
  output logic              rc_nat_o
);
  logic [DATA_W-1:0]  data_q [NUM_GPR];
  logic [NUM_GPR-1:0] nat_q;

  // entry 0 is never written, so it keeps its reset value of zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_GPR; i++) data_q[i] <= '0;
      nat_q <= '0;
    end else if (we_i && widx_i != '0) begin
      data_q[widx_i] <= wdata_i;
      nat_q[widx_i]  <= wnat_i;
    end
  end

  assign ra_data_o = data_q[ra_idx_i];
  assign ra_nat_o  = nat_q[ra_idx_i];
  assign rb_data_o = data_q[rb_idx_i];
  assign rb_nat_o  = nat_q[rb_idx_i];
  assign rc_data_o = data_q[rc_idx_i];
  assign rc_nat_o  = nat_q[rc_idx_i];
endmodule

// File: rtl/nat_spec_pred.sv
module nat_spec_pred #(
  parameter int NUM_PRED = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    pt_idx_i,
  input  logic [IDX_W-1:0]    pf_idx_i,
  input  logic                tval_i,
  input  logic                fval_i,
  output logic [NUM_PRED-1:0] pred_o
);
  logic [NUM_PRED-1:1] p_q;

  // the complement is written first, so the result wins if both indices match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= '0;
    end else if (we_i) begin
      for (int i = 1; i < NUM_PRED; i++) begin
        if (pf_idx_i == IDX_W'(i)) p_q[i] <= fval_i;
        if (pt_idx_i == IDX_W'(i)) p_q[i] <= tval_i;
      end
    end
  end

  assign pred_o = {p_q, 1'b1};
endmodule

// File: rtl/nat_spec_exec.sv
module nat_spec_exec
  import nat_spec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  op_e               op_i,
  input  logic              active_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_nat_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_nat_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ld_fault_i,
  output logic              gpr_we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wnat_o,
  output logic              pred_we_o,
  output logic              tval_o,
  output logic              fval_o,
  output logic              fault_o,
  output logic              recover_o
);
  localparam logic [DATA_W-1:0] NAT_CODE = '1;

  logic cond;
  logic any_nat;

  assign any_nat = a_nat_i | b_nat_i;
  assign cond    = (op_i == OP_CEQ) ? (a_data_i == b_data_i) : (a_data_i < b_data_i);

  always_comb begin
    gpr_we_o  = 1'b0;
    wdata_o   = '0;
    wnat_o    = 1'b0;
    pred_we_o = 1'b0;
    tval_o    = 1'b0;
    fval_o    = 1'b0;
    fault_o   = 1'b0;
    recover_o = 1'b0;
    if (active_i) begin
      case (op_i)
        OP_ADD: begin
          gpr_we_o = 1'b1;
          wdata_o  = a_data_i + b_data_i;
          wnat_o   = any_nat;
        end
        OP_SUB: begin
          gpr_we_o = 1'b1;
          wdata_o  = a_data_i - b_data_i;
          wnat_o   = any_nat;
        end
        OP_CEQ, OP_CLT: begin
          pred_we_o = 1'b1;
          tval_o    = ~any_nat & cond;
          fval_o    = ~any_nat & ~cond;
        end
        OP_LD: begin
          if (ld_fault_i) begin
            fault_o = 1'b1;
          end else begin
            gpr_we_o = 1'b1;
            wdata_o  = ld_data_i;
          end
        end
        OP_LDS: begin
          gpr_we_o = 1'b1;
          wdata_o  = ld_fault_i ? NAT_CODE : ld_data_i;
          wnat_o   = ld_fault_i;
        end
        OP_CHK: recover_o = a_nat_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nat_spec_unit.sv
module nat_spec_unit
  import nat_spec_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int NUM_GPR  = 32,
  parameter int NUM_PRED = 64,
  localparam int GIDX_W  = $clog2(NUM_GPR),
  localparam int PIDX_W  = $clog2(NUM_PRED)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [2:0]          op_i,
  input  logic [PIDX_W-1:0]   qp_i,
  input  logic [GIDX_W-1:0]   dst_i,
  input  logic [GIDX_W-1:0]   src_a_i,
  input  logic [GIDX_W-1:0]   src_b_i,
  input  logic [PIDX_W-1:0]   pt_i,
  input  logic [PIDX_W-1:0]   pf_i,
  input  logic [ADDR_W-1:0]   recov_addr_i,
  input  logic [DATA_W-1:0]   ld_data_i,
  input  logic                ld_fault_i,
  input  logic [GIDX_W-1:0]   dbg_idx_i,
  output logic [DATA_W-1:0]   dbg_data_o,
  output logic                dbg_nat_o,
  output logic [NUM_PRED-1:0] pred_o,
  output logic                recover_o,
  output logic [ADDR_W-1:0]   recover_addr_o,
  output logic                fault_o
);
  op_e               op;
  logic              active;
  logic [DATA_W-1:0] a_data, b_data, wdata;
  logic              a_nat, b_nat, wnat, gpr_we;
  logic              pred_we, tval, fval, fault_d, rec_d;

  assign op     = op_e'(op_i);
  assign active = op_valid_i & pred_o[qp_i];

  nat_spec_gpr #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_gpr (
    .clk_i, .rst_ni,
    .we_i(gpr_we), .widx_i(dst_i), .wdata_i(wdata), .wnat_i(wnat),
    .ra_idx_i(src_a_i), .ra_data_o(a_data), .ra_nat_o(a_nat),
    .rb_idx_i(src_b_i), .rb_data_o(b_data), .rb_nat_o(b_nat),
    .rc_idx_i(dbg_idx_i), .rc_data_o(dbg_data_o), .rc_nat_o(dbg_nat_o)
  );

  nat_spec_pred #(.NUM_PRED(NUM_PRED)) u_pred (
    .clk_i, .rst_ni,
    .we_i(pred_we), .pt_idx_i(pt_i), .pf_idx_i(pf_i),
    .tval_i(tval), .fval_i(fval), .pred_o(pred_o)
  );

  nat_spec_exec #(.DATA_W(DATA_W)) u_exec (
    .op_i(op), .active_i(active),
    .a_data_i(a_data), .a_nat_i(a_nat), .b_data_i(b_data), .b_nat_i(b_nat),
    .ld_data_i, .ld_fault_i,
    .gpr_we_o(gpr_we), .wdata_o(wdata), .wnat_o(wnat),
    .pred_we_o(pred_we), .tval_o(tval), .fval_o(fval),
    .fault_o(fault_d), .recover_o(rec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o        <= 1'b0;
      recover_o      <= 1'b0;
      recover_addr_o <= '0;
    end else begin
      fault_o   <= fault_d;
      recover_o <= rec_d;
      if (rec_d) recover_addr_o <= recov_addr_i;
    end
  end
endmodule

// File: rtl/nat_spec_chk.sv
module nat_spec_chk
  import nat_spec_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int NUM_GPR  = 32,
  parameter int NUM_PRED = 64,
  localparam int GIDX_W  = $clog2(NUM_GPR),
  localparam int PIDX_W  = $clog2(NUM_PRED)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                op_valid_i,
  input logic [2:0]          op_i,
  input logic [PIDX_W-1:0]   qp_i,
  input logic [ADDR_W-1:0]   recov_addr_i,
  input logic                ld_fault_i,
  input logic [GIDX_W-1:0]   dbg_idx_i,
  input logic [DATA_W-1:0]   dbg_data_o,
  input logic                dbg_nat_o,
  input logic [NUM_PRED-1:0] pred_o,
  input logic                recover_o,
  input logic [ADDR_W-1:0]   recover_addr_o,
  input logic                fault_o
);
  logic is_cmp;
  assign is_cmp = (op_i == OP_CEQ) || (op_i == OP_CLT);

  a_r4_fault_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(op_valid_i && op_i == OP_LD && ld_fault_i && pred_o[qp_i]));

  a_r5_spec_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_LDS) |=> !fault_o);

  a_r7_recover_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> $past(op_valid_i && op_i == OP_CHK && pred_o[qp_i]));

  a_r7_recover_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> recover_addr_o == $past(recov_addr_i));

  a_r8_qp_false_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !pred_o[qp_i]) |=> (!fault_o && !recover_o));

  a_r10_pred_only_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && is_cmp && pred_o[qp_i]) |=> $stable(pred_o));

  a_r9_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_idx_i == '0) |-> (dbg_data_o == '0 && !dbg_nat_o));
endmodule

bind nat_spec_unit nat_spec_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR), .NUM_PRED(NUM_PRED)
) u_chk (.*);

// File: tb/nat_spec_unit_bench.sv
module nat_spec_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op;
  logic [5:0]  qp, pt, pf;
  logic [4:0]  dst, src_a, src_b, dbg_idx;
  logic [63:0] recov_addr, ld_data, dbg_data, recover_addr;
  logic        ld_fault, dbg_nat, recover, fault;
  logic [63:0] pred;

  nat_spec_unit u_nat_spec_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .qp_i(qp),
    .dst_i(dst), .src_a_i(src_a), .src_b_i(src_b), .pt_i(pt), .pf_i(pf),
    .recov_addr_i(recov_addr), .ld_data_i(ld_data), .ld_fault_i(ld_fault),
    .dbg_idx_i(dbg_idx), .dbg_data_o(dbg_data), .dbg_nat_o(dbg_nat),
    .pred_o(pred), .recover_o(recover), .recover_addr_o(recover_addr), .fault_o(fault)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [5:0]  qp;
    logic [4:0]  dst, a, b;
    logic [5:0]  pt, pf;
    logic [63:0] ldd;
    logic        ldf;
    logic [63:0] rec;
    logic [4:0]  chk;
    logic [63:0] ed;
    logic        en, ef, er;
    logic [63:0] ep;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 22;
  // ops: 1 add, 2 sub, 3 ceq, 4 cltu, 5 ld, 6 ld.s, 7 chk
  localparam vec_t VECS [NV] = '{
    '{4'd3, 3'd5,6'd0,5'd1,5'd0,5'd0,6'd0,6'd0,64'd5,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h1},        // R3
    '{4'd3, 3'd5,6'd0,5'd2,5'd0,5'd0,6'd0,6'd0,64'd7,1'b0,64'd0,5'd2,64'd7,1'b0,1'b0,1'b0,64'h1},        // R3
    '{4'd2, 3'd1,6'd0,5'd3,5'd1,5'd2,6'd0,6'd0,64'd0,1'b0,64'd0,5'd3,64'd12,1'b0,1'b0,1'b0,64'h1},       // R2
    '{4'd2, 3'd2,6'd0,5'd4,5'd2,5'd1,6'd0,6'd0,64'd0,1'b0,64'd0,5'd4,64'd2,1'b0,1'b0,1'b0,64'h1},        // R2
    '{4'd5, 3'd6,6'd0,5'd5,5'd0,5'd0,6'd0,6'd0,64'h55,1'b1,64'd0,5'd5,ONES,1'b1,1'b0,1'b0,64'h1},        // R5
    '{4'd2, 3'd1,6'd0,5'd6,5'd5,5'd1,6'd0,6'd0,64'd0,1'b0,64'd0,5'd6,64'd4,1'b1,1'b0,1'b0,64'h1},        // R2 tag OR
    '{4'd4, 3'd5,6'd0,5'd7,5'd0,5'd0,6'd0,6'd0,64'h66,1'b1,64'd0,5'd7,64'd0,1'b0,1'b1,1'b0,64'h1},       // R4
    '{4'd7, 3'd7,6'd0,5'd0,5'd5,5'd0,6'd0,6'd0,64'd0,1'b0,64'h1000,5'd5,ONES,1'b1,1'b0,1'b1,64'h1},      // R7 hit
    '{4'd7, 3'd7,6'd0,5'd0,5'd1,5'd0,6'd0,6'd0,64'd0,1'b0,64'h2000,5'd1,64'd5,1'b0,1'b0,1'b0,64'h1},     // R7 miss
    '{4'd6, 3'd3,6'd0,5'd0,5'd1,5'd1,6'd2,6'd3,64'd0,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h5},        // R6
    '{4'd6, 3'd4,6'd0,5'd0,5'd1,5'd2,6'd4,6'd5,64'd0,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h15},       // R6
    '{4'd6, 3'd4,6'd0,5'd0,5'd2,5'd1,6'd6,6'd7,64'd0,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h95},       // R6
    '{4'd6, 3'd3,6'd0,5'd0,5'd5,5'd1,6'd2,6'd3,64'd0,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h91},       // R6 tagged
    '{4'd8, 3'd1,6'd3,5'd3,5'd1,5'd1,6'd0,6'd0,64'd0,1'b0,64'd0,5'd3,64'd12,1'b0,1'b0,1'b0,64'h91},      // R8
    '{4'd10,3'd5,6'd4,5'd8,5'd0,5'd0,6'd0,6'd0,64'd9,1'b0,64'd0,5'd8,64'd9,1'b0,1'b0,1'b0,64'h91},       // R10 qp true
    '{4'd9, 3'd5,6'd0,5'd0,5'd0,5'd0,6'd0,6'd0,64'd99,1'b0,64'd0,5'd0,64'd0,1'b0,1'b0,1'b0,64'h91},      // R9
    '{4'd10,3'd3,6'd0,5'd0,5'd1,5'd2,6'd9,6'd0,64'd0,1'b0,64'd0,5'd1,64'd5,1'b0,1'b0,1'b0,64'h91},       // R10 p0 kept
    '{4'd11,3'd1,6'd0,5'd5,5'd1,5'd2,6'd0,6'd0,64'd0,1'b0,64'd0,5'd5,64'd12,1'b0,1'b0,1'b0,64'h91},      // R11
    '{4'd11,3'd6,6'd0,5'd6,5'd0,5'd0,6'd0,6'd0,64'd3,1'b0,64'd0,5'd6,64'd3,1'b0,1'b0,1'b0,64'h91},       // R11 / R5
    '{4'd5, 3'd6,6'd0,5'd10,5'd0,5'd0,6'd0,6'd0,64'd1,1'b1,64'd0,5'd10,ONES,1'b1,1'b0,1'b0,64'h91},      // R5
    '{4'd8, 3'd7,6'd3,5'd0,5'd10,5'd0,6'd0,6'd0,64'd0,1'b0,64'h3000,5'd10,ONES,1'b1,1'b0,1'b0,64'h91},   // R8 chk
    '{4'd8, 3'd5,6'd3,5'd10,5'd0,5'd0,6'd0,6'd0,64'd8,1'b1,64'd0,5'd10,ONES,1'b1,1'b0,1'b0,64'h91}       // R8 ld
  };

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input vec_t t);
    @(negedge clk);
    op_valid = v; op = t.op; qp = t.qp; dst = t.dst; src_a = t.a; src_b = t.b;
    pt = t.pt; pf = t.pf; ld_data = t.ldd; ld_fault = t.ldf; recov_addr = t.rec;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t t;
    rst_n = 1'b0; op_valid = 1'b0; op = '0; qp = '0; dst = '0; src_a = '0; src_b = '0;
    pt = '0; pf = '0; recov_addr = '0; ld_data = '0; ld_fault = 1'b0; dbg_idx = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 32; i++) begin
      dbg_idx = 5'(i); #1;
      check($sformatf("R1 reg%0d data", i), dbg_data, 64'd0);
      check($sformatf("R1 reg%0d nat", i), {63'd0, dbg_nat}, 64'd0);
    end
    check("R1 pred", pred, 64'h1);
    check("R1 fault/recover", {62'd0, fault, recover}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      t = VECS[k];
      issue(1'b1, t);
      dbg_idx = t.chk; #1;
      check($sformatf("R%0d row%0d data", t.req, k), dbg_data, t.ed);
      check($sformatf("R%0d row%0d nat", t.req, k), {63'd0, dbg_nat}, {63'd0, t.en});
      check($sformatf("R%0d row%0d fault", t.req, k), {63'd0, fault}, {63'd0, t.ef});
      check($sformatf("R%0d row%0d recover", t.req, k), {63'd0, recover}, {63'd0, t.er});
      check($sformatf("R%0d row%0d pred", t.req, k), pred, t.ep);
      if (t.er) check($sformatf("R%0d row%0d addr", t.req, k), recover_addr, t.rec);
    end

    // R4 fault lasts one cycle
    @(negedge clk); #1;
    check("R4 fault drops", {63'd0, fault}, 64'd0);

    // R12 invalid op, and op 0, leave r1 and predicates untouched
    t = VECS[0]; t.ldd = 64'd77;
    issue(1'b0, t);
    dbg_idx = 5'd1; #1;
    check("R12 valid low r1", dbg_data, 64'd5);
    t.op = 3'd0; t.pt = 6'd1; t.pf = 6'd8;
    issue(1'b1, t);
    dbg_idx = 5'd1; #1;
    check("R12 nop r1", dbg_data, 64'd5);
    check("R12 nop pred", pred, 64'h91);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #2;
    dbg_idx = 5'd3; #1;
    check("R1 async reset r3", dbg_data, 64'd0);
    check("R1 async reset pred", pred, 64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule